// File: doc/BRIEF.md
# Clock Alarm Edge-Event Register

This block watches four alarm levels from a telecom clock synthesiser: primary reference lost, secondary reference lost, synthesiser in holdover, and synthesiser out of lock. Each level is brought into the local clock domain by a multi-stage synchroniser. Every change of each synchronised level is recorded as a sticky event. There is one event bit for the rising change and another for the falling change. While any event is pending, the block raises a level interrupt.

Software sees an eight-offset byte window.
- The live status byte shows the four synchronised levels.
- The event byte returns every captured event and clears the returned bits in the same access.
- The identification byte carries the interrupt line number in its low nibble. A value of 0xF there means that no clock hardware is present.

All offsets are read-only. A write strobe has no effect on the block. A write strobe also suppresses the clearing side-effect of a read issued in the same cycle.

After reset a small controller starts in state ST_PRIME. In this state the synchronisers fill and the edge history follows the synchronised levels, and no events are recorded. After SYNC_STAGES+1 clock edges the controller takes the transition PRIME_DONE into state ST_ARMED and stays there until the next reset. In ST_ARMED, edge capture is enabled.

Top module: `clk_alarm_evreg`

## Requirements
- R1: A read at offset 2 returns the synchronised levels on the upper nibble: bit7 is primary loss, bit6 is secondary loss, bit5 is holdover and bit4 is unlock. Bits 3..0 read zero. An input change appears there SYNC_STAGES edges after the input is sampled.
- R2: Condition index k (0 = primary loss, 1 = secondary loss, 2 = holdover, 3 = unlock; the same order as alarm_in bits) owns two event bits. A 0→1 change of its synchronised level sets event bit 2k. A 1→0 change sets event bit 2k+1. Set bits stay set until cleared by R3.
- R3: A read at offset 6 is a cycle with rd_en=1, wr_en=0 and addr=6. It returns the full event byte combinationally and clears exactly the returned bits at the next clock edge.
- R4: An edge that is detected at the same clock edge as a clearing read stays set after that read.
- R5: irq is high exactly when at least one event bit is set. It falls only in the cycle after a clearing read that leaves no event pending.
- R6: After reset, no events are recorded for the input levels present at reset, nor for any change during the first SYNC_STAGES+1 edges. Changes after that period are recorded.
- R7: A read at offset 7 returns ID_TAG on bits 7..4 and IRQ_LINE on bits 3..0. IRQ_LINE=0xF denotes absent hardware.
- R8: Reads at offsets 0, 1, 3, 4 and 5 return zero.
- R9: A cycle with wr_en=1 changes no event bit, even when rd_en=1 and addr=6.
- R10: During reset the event byte, the status byte and irq are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_in | input | 4 | Raw alarm levels: [0] primary loss, [1] secondary loss, [2] holdover, [3] unlock |
| rd_en | input | 1 | Read strobe for the register window |
| wr_en | input | 1 | Write strobe; ignored apart from suppressing a clearing read |
| addr | input | 3 | Byte offset within the window |
| rdata | output | 8 | Read data for the current offset |
| irq | output | 1 | Level interrupt, high while any event is pending |

## Verification
The bench builds the block with SYNC_STAGES=3 instead of the default 2. This lengthens both the priming period and the input-to-status latency, so that any hard-wired depth of two shows up as a mismatch against the cycle model. IRQ_LINE=9 and ID_TAG=3 give the identification byte distinct non-zero nibbles, which exposes swapped or missing fields. The long random phase issues event reads on cycles that coincide with edge detection, which brings the same-cycle keep rule and the write-suppressed clear within reach.

// File: rtl/clkalm_pkg.sv
package clkalm_pkg;

    localparam int NUM_COND = 4;
    localparam int EV_W     = 2 * NUM_COND;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;

    // condition indices, shared by alarm_in, event pairs and status bits
    localparam int C_PRI  = 0;
    localparam int C_SEC  = 1;
    localparam int C_HOLD = 2;
    localparam int C_UNLK = 3;

    // offsets that software decodes
    localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_EVENT  = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_IDENT  = 3'd7;

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_e;

endpackage

// File: rtl/clkalm_sync.sv
module clkalm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= d;
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else begin
                stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/clkalm_evcap.sv
module clkalm_evcap
    import clkalm_pkg::*;
#(
    parameter int NCOND = NUM_COND
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCOND-1:0]   lvl,
    input  logic               capture_en,
    input  logic               clear_rd,
    output logic [2*NCOND-1:0] ev_q
);
    localparam int NEV = 2 * NCOND;

    logic [NCOND-1:0] hist_q;
    logic [NEV-1:0]   edges;
    logic [NEV-1:0]   keep_mask;
    logic [NEV-1:0]   ev_d;

    // each condition owns an adjacent pair: even = rose, odd = fell
    for (genvar k = 0; k < NCOND; k++) begin : g_pair
        assign edges[2*k]   =  lvl[k] & ~hist_q[k];
        assign edges[2*k+1] = ~lvl[k] &  hist_q[k];
    end

    always_comb begin
        keep_mask = clear_rd ? ~ev_q : {NEV{1'b1}};
        ev_d      = ev_q & keep_mask;
        if (capture_en) begin
            ev_d = ev_d | edges;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            ev_q   <= '0;
        end else begin
            hist_q <= lvl;
            ev_q   <= ev_d;
        end
    end

endmodule

// File: rtl/clkalm_regmux.sv
module clkalm_regmux
    import clkalm_pkg::*;
#(
    parameter logic [3:0] IRQ_LINE = 4'hF,
    parameter logic [3:0] ID_TAG   = 4'h0
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_COND-1:0] lvl,
    input  logic [EV_W-1:0]     ev,
    output logic [DATA_W-1:0]   rdata
);
    logic [DATA_W-1:0] status_byte;

    assign status_byte = {lvl[C_PRI], lvl[C_SEC], lvl[C_HOLD], lvl[C_UNLK], 4'b0000};

    always_comb begin
        unique case (addr)
            OFS_STATUS: rdata = status_byte;
            OFS_EVENT:  rdata = ev;
            OFS_IDENT:  rdata = {ID_TAG, IRQ_LINE};
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/clk_alarm_evreg.sv
module clk_alarm_evreg
    import clkalm_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] IRQ_LINE    = 4'h5,
    parameter logic [3:0] ID_TAG      = 4'h1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_COND-1:0] alarm_in,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    output logic [DATA_W-1:0]   rdata,
    output logic                irq
);
    localparam int PRIME_LAST = SYNC_STAGES;
    localparam int CNT_W      = $clog2(SYNC_STAGES + 1);

    arm_state_e          state_q, state_d;
    logic [CNT_W-1:0]    prime_cnt_q;
    logic                capture_en;
    logic                clear_rd;
    logic [NUM_COND-1:0] lvl_sync;
    logic [EV_W-1:0]     ev_q;

    // ---------------- controller: state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prime_cnt_q <= '0;
        end else if (state_q == ST_PRIME) begin
            prime_cnt_q <= prime_cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: if (prime_cnt_q == CNT_W'(PRIME_LAST)) state_d = ST_ARMED; // PRIME_DONE
            ST_ARMED: state_d = ST_ARMED;
            default:  state_d = ST_PRIME;
        endcase
    end

    // ---------------- controller: outputs ----------------
    always_comb begin
        capture_en = 1'b0;
        unique case (state_q)
            ST_PRIME: capture_en = 1'b0;
            ST_ARMED: capture_en = 1'b1;
            default:  capture_en = 1'b0;
        endcase
    end

    assign clear_rd = rd_en && !wr_en && (addr == OFS_EVENT);

    clkalm_sync #(
        .WIDTH  (NUM_COND),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (alarm_in),
        .q     (lvl_sync)
    );

    clkalm_evcap #(
        .NCOND (NUM_COND)
    ) u_evcap (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (lvl_sync),
        .capture_en (capture_en),
        .clear_rd   (clear_rd),
        .ev_q       (ev_q)
    );

    clkalm_regmux #(
        .IRQ_LINE (IRQ_LINE),
        .ID_TAG   (ID_TAG)
    ) u_mux (
        .addr  (addr),
        .lvl   (lvl_sync),
        .ev    (ev_q),
        .rdata (rdata)
    );

    assign irq = |ev_q;

endmodule

// File: rtl/clkalm_checker.sv
module clkalm_checker
    import clkalm_pkg::*;
#(
    parameter logic [3:0] IRQ_LINE = 4'h5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_en,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   rdata,
    input logic                irq,
    input logic [EV_W-1:0]     ev_q,
    input logic                capture_en
);
    logic is_clear;
    assign is_clear = rd_en && !wr_en && (addr == OFS_EVENT);

    assert_status_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_STATUS) |-> (rdata[3:0] == 4'h0));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !is_clear |=> (($past(ev_q) & ~ev_q) == '0));

    assert_read_returns_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_clear |-> (rdata == ev_q));

    assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(is_clear));

    assert_no_prime_events_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_en |-> (ev_q == '0));

    assert_ident_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_IDENT) |-> (rdata[3:0] == IRQ_LINE));

    assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != OFS_STATUS && addr != OFS_EVENT && addr != OFS_IDENT) |-> (rdata == '0));

    assert_write_no_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (($past(ev_q) & ~ev_q) == '0));

endmodule

bind clk_alarm_evreg clkalm_checker #(
    .IRQ_LINE (IRQ_LINE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .addr       (addr),
    .rdata      (rdata),
    .irq        (irq),
    .ev_q       (ev_q),
    .capture_en (capture_en)
);

// File: tb/tb_clk_alarm_evreg.sv
`timescale 1ns/1ps
module tb_clk_alarm_evreg;

    localparam int         S      = 3;
    localparam logic [3:0] LINE   = 4'h9;
    localparam logic [3:0] TAG    = 4'h3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] alarm_in = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] rdata;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic rst_drv = 1'b0;

    // behavioural reference state
    logic [3:0] m_pipe [S];
    logic [3:0] m_hist;
    logic [7:0] m_ev;
    int         m_cnt;
    bit         m_armed;

    always #10 clk = ~clk;

    clk_alarm_evreg #(
        .SYNC_STAGES (S),
        .IRQ_LINE    (LINE),
        .ID_TAG      (TAG)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .alarm_in (alarm_in),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .rdata    (rdata),
        .irq      (irq)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < S; i++) m_pipe[i] = '0;
        m_hist = '0; m_ev = '0; m_cnt = 0; m_armed = 0;
    endtask

    function automatic logic [7:0] model_read(input logic [2:0] a);
        logic [3:0] lv = m_pipe[S-1];
        case (a)
            3'd2:    return {lv[0], lv[1], lv[2], lv[3], 4'b0};
            3'd6:    return m_ev;
            3'd7:    return {TAG, LINE};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_step(input logic [3:0] a, input logic r, input logic w, input logic [2:0] ad);
        logic [3:0] lv = m_pipe[S-1];
        logic [7:0] nev = '0;
        if (m_armed) begin
            for (int k = 0; k < 4; k++) begin
                if (lv[k] && !m_hist[k]) nev[2*k] = 1'b1;
                if (!lv[k] && m_hist[k]) nev[2*k+1] = 1'b1;
            end
        end
        if (r && !w && ad == 3'd6) m_ev = '0;
        m_ev = m_ev | nev;
        m_hist = lv;
        for (int i = S - 1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
        m_pipe[0] = a;
        if (!m_armed) begin
            if (m_cnt == S) m_armed = 1;
            else m_cnt++;
        end
    endtask

    // one clock: drive at negedge, compare against model, then advance model
    task automatic cyc(input logic [3:0] a, input logic r, input logic w,
                       input logic [2:0] ad, output logic [7:0] got);
        @(negedge clk);
        rst_n = rst_drv; alarm_in = a; rd_en = r; wr_en = w; addr = ad;
        #1;
        got = rdata;
        if (!rst_n) model_reset();
        case (ad)
            3'd2:    check(rdata, model_read(ad), "R1 status");
            3'd6:    check(rdata, model_read(ad), "R3 event byte");
            3'd7:    check(rdata, model_read(ad), "R7 ident");
            default: check(rdata, model_read(ad), "R8 unused");
        endcase
        check({7'b0, irq}, {7'b0, (m_ev != 0)}, "R5 irq");
        if (rst_n) model_step(a, r, w, ad);
    endtask

    initial begin
        logic [7:0] g;
        logic [7:0] acc;
        logic [3:0] lvl;
        logic [15:0] lf;
        model_reset();

        // R10: reset values, inputs already high for sec loss and unlock
        lvl = 4'b1010;
        rst_drv = 1'b0;
        cyc(lvl, 1'b0, 1'b0, 3'd6, g); check(g, 8'h00, "R10 event in reset");
        cyc(lvl, 1'b0, 1'b0, 3'd2, g); check(g, 8'h00, "R10 status in reset");
        check({7'b0, irq}, 8'h00, "R10 irq in reset");
        rst_drv = 1'b1;
        for (int i = 0; i < 10; i++) cyc(lvl, 1'b0, 1'b0, 3'd2, g);
        check(g, 8'h50, "R1 status levels");
        cyc(lvl, 1'b0, 1'b0, 3'd6, g); check(g, 8'h00, "R6 no false events");

        // R2: primary loss rises
        lvl = 4'b1011;
        for (int i = 0; i < S + 2; i++) cyc(lvl, 1'b0, 1'b0, 3'd7, g);
        check(g, {TAG, LINE}, "R7 ident value");
        check({7'b0, irq}, 8'h01, "R5 irq set");
        cyc(lvl, 1'b1, 1'b0, 3'd6, g); check(g, 8'h01, "R2 primary rose");
        cyc(lvl, 1'b0, 1'b0, 3'd6, g); check(g, 8'h00, "R3 cleared");
        check({7'b0, irq}, 8'h00, "R5 irq dropped");

        // R2: unlock falls, holdover rises
        lvl = 4'b0111;
        for (int i = 0; i < S + 2; i++) cyc(lvl, 1'b0, 1'b0, 3'd0, g);
        // R9: write with read at event offset does not clear
        cyc(lvl, 1'b1, 1'b1, 3'd6, g);
        cyc(lvl, 1'b0, 1'b0, 3'd6, g); check(g, 8'h90, "R9 write kept events");
        cyc(lvl, 1'b1, 1'b0, 3'd6, g); check(g, 8'h90, "R2 unlock fell holdover rose");

        // R4: read every cycle across an edge, nothing lost
        lvl = 4'b0101;
        acc = '0;
        for (int i = 0; i < S + 4; i++) begin
            cyc(lvl, 1'b1, 1'b0, 3'd6, g);
            acc = acc | g;
        end
        check(acc, 8'h08, "R4 same-cycle edge kept");

        // R8: unused offsets
        for (int o = 0; o < 6; o++) begin
            if (o != 2) begin
                cyc(lvl, 1'b1, 1'b0, 3'(o), g);
                check(g, 8'h00, "R8 unused offset");
            end
        end

        // pseudo-random traffic against the model
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[3:1] == 3'b000) lvl[lf[5:4]] = ~lvl[lf[5:4]];
            cyc(lvl, lf[7], lf[9] & lf[11], lf[14:12], g);
        end

        // R6: reset again mid-activity with different levels, then quiet
        rst_drv = 1'b0;
        lvl = 4'b1100;
        cyc(lvl, 1'b0, 1'b0, 3'd6, g);
        rst_drv = 1'b1;
        for (int i = 0; i < 8; i++) cyc(lvl, 1'b0, 1'b0, 3'd6, g);
        check(g, 8'h00, "R6 no events after second reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule